// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block serialises characters onto a single output line in the usual asynchronous framing. A host writes a character into a one-entry holding register with a single-cycle write strobe. The character moves into a shift register, which sends one bit for each pulse of an externally generated baud tick. Because of the holding register, the host can queue the next character while the current one is still on the wire. The queued character then follows with no idle gap.

The host chooses a character length of 8 or 9 data bits and a stop-bit count of 1 or 2. The host supplies the ninth bit, so any parity is its own concern. A polarity control complements the whole line, idle level included. A buffer-empty flag tells the host when a write will be accepted. The flag follows the holding-register state with a fixed one-cycle lag. An interrupt output is the flag gated by an enable. The transmitter runs only when both enables are set and the synchronous-mode select is clear. Dropping out of that condition aborts everything at once.

Top module: `async_tx_dbuf`

## Requirements
- R1: While no character is in the shifter, `txd` sits at the mark level: 1 with `pol_invert`=0.
- R2: A frame is one start bit of 0, then the data bits with `wr_data[0]` first, then the stop bits of 1. In 9-bit mode (`nine_bit`=1) the value of `wr_bit9` captured with the character goes out as the last data bit.
- R3: Every bit lasts exactly one baud period, and bit boundaries fall only on clock edges where `baud_tick`=1. A character loaded into an idle shifter raises `busy` on the next edge. It keeps the line idle until the first tick, and its start bit begins on that edge.
- R4: A character held while the shifter is busy moves across on the tick edge that ends the previous last stop bit. Its start bit begins on that same edge. A write arriving in that cycle with an empty holding register is loaded straight into the shifter.
- R5: `nine_bit` picks 9 data bits (1) or 8 (0). `two_stop` picks 2 stop bits (1) or 1 (0). Both are captured when a character enters the shifter.
- R6: The transmitter runs only while `tx_enable`=1, `port_enable`=1 and `sync_sel`=0. Otherwise the frame in progress is aborted, both registers empty, `busy` falls, the line returns to idle, writes are ignored, and `buf_empty` reads 0 from the next edge on.
- R7: While running, `buf_empty` is 0 only when the shifter is busy and a second character waits in the holding register. It is 1 otherwise, whatever `irq_enable` is.
- R8: `buf_empty` lags the holding register by one clock edge. After a write strobe sampled at edge k, the flag still shows its old value between edges k and k+1 and shows the new value after edge k+1.
- R9: With `pol_invert`=1, every level on `txd` is complemented: idle, start, data and stop.
- R10: A write while the holding register is full is dropped, and the character already held is sent unchanged.
- R11: `irq` equals `buf_empty` AND `irq_enable`. `busy` is 1 from the edge a character enters the shifter until the tick edge ending its last stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_enable | input | 1 | Transmitter enable |
| port_enable | input | 1 | Serial port enable |
| sync_sel | input | 1 | Synchronous mode select; must be 0 to run |
| pol_invert | input | 1 | Complement the whole output line |
| nine_bit | input | 1 | 9 data bits when 1, 8 when 0 |
| two_stop | input | 1 | 2 stop bits when 1, 1 when 0 |
| irq_enable | input | 1 | Interrupt enable |
| wr_stb | input | 1 | Single-cycle write strobe for the holding register |
| wr_data | input | DATA_W | Character data |
| wr_bit9 | input | 1 | Ninth data bit, used in 9-bit mode |
| baud_tick | input | 1 | One-cycle pulse per baud period |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding register free (lagged by one cycle) |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Shifter holds a character |

## Verification
The bench uses the default parameters: 8-bit base characters, a 2-bit stop maximum and a one-stage flag lag. This keeps a frame at 10 to 12 baud periods, so back-to-back queues, dropped writes and aborts all fit in short runs. It changes the baud divider between 1 (a tick on every cycle), 3 and 5. With a tick on every cycle, the end-of-character edge and the write strobe line up often. That exercises the direct load into the shifter at the end of a frame and the one-cycle stale flag read. A random phase mixes both format controls, polarity, interrupt enable and short disable pulses against a queue-based line model.

// File: rtl/tx_pkg.sv
package tx_pkg;

  localparam int STOP_MAX = 2;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_WAIT = 2'd1,
    SH_SEND = 2'd2
  } sh_state_t;

  // Number of line bits in one frame: start + data (+ ninth) + stops.
  function automatic int frame_len(input int data_w, input logic nine, input logic two);
    int n;
    n = 1 + data_w + 1;
    if (nine) n = n + 1;
    if (two)  n = n + 1;
    return n;
  endfunction

endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int CHAR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              set,
  input  logic              clr,
  input  logic [CHAR_W-1:0] d_in,
  output logic [CHAR_W-1:0] q_out,
  output logic              full
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full  <= 1'b0;
      q_out <= '0;
    end else if (!run) begin
      full  <= 1'b0;
      q_out <= '0;
    end else if (clr) begin
      full  <= 1'b0;
    end else if (set) begin
      full  <= 1'b1;
      q_out <= d_in;
    end
  end

  // R10
  held_data_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && run && !clr) |=> $stable(q_out));

  // R10
  no_set_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set && full));

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W:0]   load_char,
  input  logic              nine,
  input  logic              two_stop,
  output logic              line,
  output logic              sh_busy,
  output logic              free_next
);

  localparam int CHAR_W  = DATA_W + 1;
  localparam int FRAME_W = 1 + CHAR_W + STOP_MAX;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  sh_state_t          state;
  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   cnt;
  logic               last_bit_done;

  // Line image of one frame, LSB first; unused upper positions stay at mark.
  function automatic logic [FRAME_W-1:0] make_frame(input logic [CHAR_W-1:0] c,
                                                    input logic nine_sel);
    logic [FRAME_W-1:0] f;
    f    = '1;
    f[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) f[1+i] = c[i];
    if (nine_sel) f[1+DATA_W] = c[DATA_W];
    return f;
  endfunction

  assign last_bit_done = (state == SH_SEND) && tick && (cnt == CNT_W'(1));
  assign free_next     = (state == SH_IDLE) || last_bit_done;
  assign sh_busy       = (state != SH_IDLE);
  assign line          = (state == SH_SEND) ? sreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SH_IDLE;
      sreg  <= '1;
      cnt   <= '0;
    end else if (!run) begin
      state <= SH_IDLE;
      sreg  <= '1;
      cnt   <= '0;
    end else begin
      case (state)
        SH_WAIT: if (tick) state <= SH_SEND;
        SH_SEND: if (tick) begin
          if (cnt == CNT_W'(1)) begin
            state <= SH_IDLE;
          end else begin
            sreg <= {1'b1, sreg[FRAME_W-1:1]};
            cnt  <= cnt - CNT_W'(1);
          end
        end
        default: ;
      endcase
      if (load) begin
        sreg  <= make_frame(load_char, nine);
        cnt   <= CNT_W'(frame_len(DATA_W, nine, two_stop));
        state <= (state == SH_IDLE) ? SH_WAIT : SH_SEND;
      end
    end
  end

  // R3
  bit_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && state == SH_SEND && tick && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && state == SH_SEND && !tick) |=> $stable(sreg));

  // R4
  load_only_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> free_next);

endmodule

// File: rtl/tx_flag_pipe.sv
module tx_flag_pipe #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic raw,
  output logic flag
);

  logic [STAGES-1:0] pipe;
  logic [STAGES-1:0] stage_in;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign stage_in[i] = raw;
      end else begin : g_rest
        assign stage_in[i] = pipe[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pipe[i] <= 1'b0;
        else if (!run) pipe[i] <= 1'b0;
        else           pipe[i] <= stage_in[i];
      end
    end
  endgenerate

  assign flag = pipe[STAGES-1];

  // R8
  flag_rise_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(stage_in[STAGES-1]));

  // R6
  flag_low_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !flag);

endmodule

// File: rtl/async_tx_dbuf.sv
module async_tx_dbuf
  import tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FLAG_LAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic              port_enable,
  input  logic              sync_sel,
  input  logic              pol_invert,
  input  logic              nine_bit,
  input  logic              two_stop,
  input  logic              irq_enable,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              baud_tick,
  output logic              txd,
  output logic              buf_empty,
  output logic              irq,
  output logic              busy
);

  localparam int CHAR_W = DATA_W + 1;

  logic              run;
  logic              wr_acc;
  logic              hold_full;
  logic [CHAR_W-1:0] hold_q;
  logic              hold_set;
  logic              hold_clr;
  logic              sh_load;
  logic [CHAR_W-1:0] sh_char;
  logic              sh_line;
  logic              sh_busy;
  logic              sh_free_next;
  logic              raw_empty;

  assign run      = tx_enable & port_enable & ~sync_sel;
  assign wr_acc   = run & wr_stb & ~hold_full;
  assign sh_load  = sh_free_next & (hold_full | wr_acc);
  assign sh_char  = hold_full ? hold_q : {wr_bit9, wr_data};
  assign hold_set = wr_acc & ~sh_free_next;
  assign hold_clr = sh_free_next & hold_full;
  assign raw_empty = run & ~hold_full;

  tx_hold_reg #(.CHAR_W(CHAR_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .set   (hold_set),
    .clr   (hold_clr),
    .d_in  ({wr_bit9, wr_data}),
    .q_out (hold_q),
    .full  (hold_full)
  );

  tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (baud_tick),
    .load      (sh_load),
    .load_char (sh_char),
    .nine      (nine_bit),
    .two_stop  (two_stop),
    .line      (sh_line),
    .sh_busy   (sh_busy),
    .free_next (sh_free_next)
  );

  tx_flag_pipe #(.STAGES(FLAG_LAG)) u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .raw   (raw_empty),
    .flag  (buf_empty)
  );

  assign txd  = pol_invert ^ sh_line;
  assign busy = sh_busy;
  assign irq  = buf_empty & irq_enable;

  // R7
  hold_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full |-> sh_busy);

  // R1
  idle_line_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (txd == ~pol_invert));

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!busy && !hold_full));

  // R10
  full_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_stb && hold_full && !sh_free_next) |=> hold_full);

endmodule

// File: tb/tb_async_tx_dbuf.sv
module tb_async_tx_dbuf;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_enable = 1'b0, port_enable = 1'b0, sync_sel = 1'b0;
  logic       pol_invert = 1'b0, nine_bit = 1'b0, two_stop = 1'b0, irq_enable = 1'b0;
  logic       wr_stb = 1'b0, wr_bit9 = 1'b0, baud_tick = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd, buf_empty, irq, busy;

  int vectors = 0, miscompares = 0;
  int div = 3, tcnt = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  async_tx_dbuf dut (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .port_enable(port_enable),
    .sync_sel(sync_sel), .pol_invert(pol_invert), .nine_bit(nine_bit),
    .two_stop(two_stop), .irq_enable(irq_enable), .wr_stb(wr_stb),
    .wr_data(wr_data), .wr_bit9(wr_bit9), .baud_tick(baud_tick),
    .txd(txd), .buf_empty(buf_empty), .irq(irq), .busy(busy)
  );

  // Behavioural reference: line bits of the current frame kept in a queue.
  int   m_st = 0;       // 0 idle, 1 waiting for tick, 2 sending
  bit   m_q[$];
  bit   m_hf = 0;
  bit [8:0] m_hv = '0;
  bit   m_flag = 0;

  always @(posedge clk) begin
    bit run, acc, endc, fre;
    bit [8:0] src;
    if (!rst_n) begin
      m_st = 0; m_q.delete(); m_hf = 0; m_flag = 0;
    end else begin
      run = tx_enable && port_enable && !sync_sel;
      if (!run) begin
        m_st = 0; m_q.delete(); m_hf = 0; m_flag = 0;
      end else begin
        acc  = wr_stb && !m_hf;
        endc = (m_st == 2) && baud_tick && (m_q.size() == 1);
        fre  = (m_st == 0) || endc;
        m_flag = !m_hf;
        if (m_st == 1 && baud_tick) m_st = 2;
        else if (m_st == 2 && baud_tick) begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) m_st = 0;
        end
        if (fre && (m_hf || acc)) begin
          src = m_hf ? m_hv : {wr_bit9, wr_data};
          m_q.delete();
          m_q.push_back(1'b0);
          for (int i = 0; i < 8; i++) m_q.push_back(src[i]);
          if (nine_bit) m_q.push_back(src[8]);
          m_q.push_back(1'b1);
          if (two_stop) m_q.push_back(1'b1);
          m_st = endc ? 2 : 1;
          m_hf = 0;
        end else if (acc) begin
          m_hf = 1;
          m_hv = {wr_bit9, wr_data};
        end
      end
    end
  end

  task automatic check_eq(string req, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit e_txd;
    e_txd = pol_invert ^ ((m_st == 2) ? m_q[0] : 1'b1);
    check_eq(cur_req, "txd", txd, e_txd);
    check_eq(cur_req, "busy", busy, (m_st != 0));
    check_eq(cur_req, "buf_empty", buf_empty, m_flag);
    check_eq("R11", "irq", irq, m_flag & irq_enable);
  endtask

  // One clock: compare at the falling edge, then set the next tick.
  task automatic cyc();
    @(negedge clk);
    compare_all();
    baud_tick = ((tcnt % div) == div - 1);
    tcnt++;
  endtask

  task automatic wr(input logic [7:0] d, input logic b9);
    wr_stb = 1'b1; wr_data = d; wr_bit9 = b9;
    cyc();
    wr_stb = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      if (m_st == 0 && !m_hf) break;
      cyc();
    end
    repeat (3) cyc();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state
    check_eq("R1", "reset txd", txd, 1);
    check_eq("R6", "reset busy", busy, 0);
    check_eq("R6", "reset buf_empty", buf_empty, 0);
    rst_n = 1'b1;
    tx_enable = 1'b1; port_enable = 1'b1;
    cur_req = "R1";
    repeat (6) cyc();
    check_eq("R7", "empty when idle", buf_empty, 1);

    // Plain 8-bit frames at several dividers
    cur_req = "R2";
    wr(8'hA5, 1'b0);
    check_eq("R3", "busy after load", busy, 1);
    wait_idle();
    div = 1;
    cur_req = "R3";
    wr(8'h3C, 1'b0);
    wait_idle();
    div = 5;

    // 9-bit, two stop bits
    cur_req = "R5";
    nine_bit = 1'b1; two_stop = 1'b1;
    wr(8'h81, 1'b1);
    wait_idle();
    wr(8'h7E, 1'b0);
    wait_idle();
    nine_bit = 1'b0; two_stop = 1'b0;

    // Queued character, stale flag, dropped write
    cur_req = "R4";
    wr(8'h55, 1'b0);
    repeat (4) cyc();
    wr(8'hC3, 1'b0);
    check_eq("R8", "stale flag after write", buf_empty, 1);
    cyc();
    check_eq("R8", "flag after lag", buf_empty, 0);
    check_eq("R7", "busy and full", busy, 1);
    cur_req = "R10";
    wr(8'h00, 1'b1);
    wait_idle();

    // Back-to-back at tick-every-cycle
    div = 1;
    cur_req = "R4";
    wr(8'hF0, 1'b0);
    wr(8'h0F, 1'b0);
    wait_idle();
    div = 3;

    // Inverted polarity
    cur_req = "R9";
    pol_invert = 1'b1;
    repeat (3) cyc();
    check_eq("R9", "inverted idle", txd, 0);
    wr(8'h96, 1'b0);
    wait_idle();
    pol_invert = 1'b0;

    // Interrupt gating
    cur_req = "R11";
    irq_enable = 1'b1;
    repeat (3) cyc();
    check_eq("R11", "irq with empty", irq, 1);
    wr(8'h11, 1'b0);
    wr(8'h22, 1'b0);
    cyc();
    check_eq("R11", "irq low while full", irq, 0);
    wait_idle();

    // Abort by disable, writes while off ignored
    cur_req = "R6";
    wr(8'h5A, 1'b0);
    repeat (7) cyc();
    wr(8'hA5, 1'b0);
    tx_enable = 1'b0;
    cyc();
    cyc();
    check_eq("R6", "busy after disable", busy, 0);
    check_eq("R6", "flag after disable", buf_empty, 0);
    check_eq("R6", "line after disable", txd, 1);
    wr(8'h99, 1'b0);
    repeat (3) cyc();
    check_eq("R6", "write while off", busy, 0);
    tx_enable = 1'b1;
    sync_sel = 1'b1;
    repeat (3) cyc();
    check_eq("R6", "sync mode blocks", buf_empty, 0);
    sync_sel = 1'b0;
    repeat (3) cyc();

    // Random mix
    cur_req = "R7";
    for (int n = 0; n < 6000; n++) begin
      if (n % 1500 == 0) div = 1 + 2 * ((n / 1500) % 3);
      wr_stb     = (($urandom % 6) == 0);
      wr_data    = 8'($urandom);
      wr_bit9    = 1'($urandom);
      if (($urandom % 40) == 0) nine_bit = ~nine_bit;
      if (($urandom % 40) == 0) two_stop = ~two_stop;
      if (($urandom % 300) == 0) pol_invert = ~pol_invert;
      if (($urandom % 20) == 0) irq_enable = ~irq_enable;
      port_enable = (($urandom % 400) != 0);
      cyc();
    end
    wr_stb = 1'b0; port_enable = 1'b1;
    wait_idle();
    finish_run();
  end

endmodule